// File: doc/BRIEF.md
# Sticky Link and Media Status Word

This block holds a 16-bit read-only status word for a two-port 10/100 media converter, with one copper (twisted-pair) port and one fiber port. Raw indications from the port detectors enter on a 16-bit live vector. They cover detected speed, link, auto-negotiation completion, packet activity, link-pulse bursts, far-end fault, PLL lock, PLL frequency error and descrambler seed loss. Every indication passes through one synchronizing flop. The word then applies a rule to each bit: the bit shows live, latches high until read, latches low until read, or is masked by the operating mode or by the speed-detect bits.

A management agent reads the word by raising a read strobe with the 5-bit register address. When the address is 27, the current word appears combinationally on the data output. The latched bits are cleared on the clock edge that ends the strobe cycle. An event that arrives at that same edge is kept for the next read. The detectors and the serial management framing sit outside this block.

Top module: `linkStatusReg`

## Requirements
- R1: When `rdStrobe` is high and `regAddr` equals 27, `rdData` carries the status word. In every other case `rdData` is 0.
- R2: The live bits show their `liveIn` value one clock after it changes. These are: bit 1 auto-negotiation done, bit 2 copper 10M, bit 3 copper 100M, bit 6 fiber 10M, bit 7 fiber 100M, bit 9 fiber link-pulse burst, bit 10 fiber far-end fault, bit 11 copper PLL lock, bit 12 copper PLL frequency error, bit 13 fiber PLL lock and bit 14 fiber PLL frequency error.
- R3: Bit 0 (copper link) latches low. After `liveIn[0]` falls, bit 0 reads 0 until a read of the word, even if the link recovers. After that read it shows the live value again.
- R4: While `transparentMode` is 1, bits 0 and 1 read 0.
- R5: Bit 4 (copper packet) latches high on a pulse of `liveIn[4]` and is cleared by a read. It reads 0 while bits 2 and 3 are both 0.
- R6: Bit 8 (fiber packet) latches high on a pulse of `liveIn[8]` and is cleared by a read. It reads 0 while bits 6 and 7 are both 0.
- R7: Bit 15 (descrambler seed lost) latches high on a pulse of `liveIn[15]` and is cleared by a read.
- R8: Bit 5 (copper fast-link-pulse) follows `liveIn[5]`. It also reads 1 when `tpNlpBurst` is 1 and `tpPeclMode` is 1.
- R9: A latch-high event that reaches the latch on the same edge as a read clear is not lost. It appears on the following read.
- R10: After reset, bits 4, 8 and 15 read 0, and bit 0 shows the live link value without any recorded drop.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Management register address |
| rdStrobe | input | 1 | Read strobe, one cycle per read |
| transparentMode | input | 1 | Transparent mode; masks link and auto-negotiation bits |
| tpPeclMode | input | 1 | Copper port uses the PECL interface |
| tpNlpBurst | input | 1 | Normal-link-pulse burst seen on the copper port |
| liveIn | input | 16 | Raw indications, indexed like the status word |
| rdData | output | 16 | Read data |

## Verification
The bench drops the copper link for a single cycle and then restores it. A design that let bit 0 follow the live value would hide the drop. A packet pulse is timed to reach its latch on the very edge the read clears it, and a design that gave the clear priority would lose that event. The packet pulses are also sent while the matching speed bits are low, which exposes a missing qualifier. The one-flop delay of the live bits is probed by reading in the cycle the input changes, and the mode masks (transparent mode, and the normal-link-pulse path under PECL) are toggled in both directions.

// File: rtl/linkStatusPkg.sv
package linkStatusPkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 5;

  localparam int B_LINK   = 0;
  localparam int B_ANDONE = 1;
  localparam int B_TP10   = 2;
  localparam int B_TP100  = 3;
  localparam int B_TPPKT  = 4;
  localparam int B_TPFLP  = 5;
  localparam int B_FI10   = 6;
  localparam int B_FI100  = 7;
  localparam int B_FIPKT  = 8;
  localparam int B_NOSEED = 15;

  localparam logic [REG_W-1:0] LATCH_HI_MASK =
    REG_W'((1 << B_TPPKT) | (1 << B_FIPKT) | (1 << B_NOSEED));

  typedef struct packed {
    logic rdHit;
    logic clrLatch;
  } ctrlStrobeT;
endpackage

// File: rtl/linkStatusCtrl.sv
module linkStatusCtrl
  import linkStatusPkg::*;
#(
  parameter int unsigned REG_ADDR = 27
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdStrobe,
  output ctrlStrobeT        strobes
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic addrMatch;
  assign addrMatch        = (regAddr == MY_ADDR);
  assign strobes.rdHit    = rdStrobe & addrMatch;
  assign strobes.clrLatch = rdStrobe & addrMatch;
endmodule

// File: rtl/linkStatusDatapath.sv
module linkStatusDatapath
  import linkStatusPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic             transparentMode,
  input  logic             tpPeclMode,
  input  logic             tpNlpBurst,
  input  logic [REG_W-1:0] liveIn,
  output logic [REG_W-1:0] rdData
);
  logic [REG_W-1:0] liveQ;
  logic             nlpQ;
  logic             linkPrevQ;
  logic             dropSeenQ;
  logic [REG_W-1:0] latchHiQ;
  logic [REG_W-1:0] latchHiNext;
  logic [REG_W-1:0] regValue;
  logic             dropEvt;

  // single synchronizing stage for every raw indication
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ     <= '0;
      nlpQ      <= 1'b0;
      linkPrevQ <= 1'b0;
    end else begin
      liveQ     <= liveIn;
      nlpQ      <= tpNlpBurst;
      linkPrevQ <= liveQ[B_LINK];
    end
  end

  // latch-high bits: event ORed after clear so a coincident event survives
  assign latchHiNext = ((latchHiQ & ~{REG_W{strobes.clrLatch}}) | liveQ) & LATCH_HI_MASK;

  // latch-low link: remember a falling edge until the word is read
  assign dropEvt = linkPrevQ & ~liveQ[B_LINK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchHiQ  <= '0;
      dropSeenQ <= 1'b0;
    end else begin
      latchHiQ  <= latchHiNext;
      dropSeenQ <= (dropSeenQ & ~strobes.clrLatch) | dropEvt;
    end
  end

  always_comb begin
    regValue = (liveQ & ~LATCH_HI_MASK) | latchHiQ;
    regValue[B_LINK]   = liveQ[B_LINK] & ~dropSeenQ & ~transparentMode;
    regValue[B_ANDONE] = liveQ[B_ANDONE] & ~transparentMode;
    regValue[B_TPPKT]  = latchHiQ[B_TPPKT] & (liveQ[B_TP10] | liveQ[B_TP100]);
    regValue[B_FIPKT]  = latchHiQ[B_FIPKT] & (liveQ[B_FI10] | liveQ[B_FI100]);
    regValue[B_TPFLP]  = liveQ[B_TPFLP] | (tpPeclMode & nlpQ);
  end

  assign rdData = strobes.rdHit ? regValue : '0;

  // R3: a synchronized falling edge of link is recorded on the next edge
  p_drop_latched_r3: assert property (@(posedge clk) disable iff (!rstN)
    (linkPrevQ && !liveQ[B_LINK]) |=> dropSeenQ);

  // R3: a recorded drop holds until a read
  p_drop_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dropSeenQ && !strobes.clrLatch) |=> dropSeenQ);

  for (genvar i = 0; i < REG_W; i++) begin : g_bitChk
    if (LATCH_HI_MASK[i]) begin : g_hi
      // R9: an event seen by the latch is never lost, clear or not
      p_evt_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
        liveQ[i] |=> latchHiQ[i]);
      // R5 R6 R7: a read with no new event clears the latch
      p_read_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.clrLatch && !liveQ[i]) |=> !latchHiQ[i]);
    end
  end
endmodule

// File: rtl/linkStatusReg.sv
module linkStatusReg
  import linkStatusPkg::*;
#(
  parameter int unsigned REG_ADDR = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdStrobe,
  input  logic              transparentMode,
  input  logic              tpPeclMode,
  input  logic              tpNlpBurst,
  input  logic [REG_W-1:0]  liveIn,
  output logic [REG_W-1:0]  rdData
);
  ctrlStrobeT strobes;

  linkStatusCtrl #(.REG_ADDR(REG_ADDR)) uCtrl (
    .regAddr (regAddr),
    .rdStrobe(rdStrobe),
    .strobes (strobes)
  );

  linkStatusDatapath uDp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .transparentMode(transparentMode),
    .tpPeclMode     (tpPeclMode),
    .tpNlpBurst     (tpNlpBurst),
    .liveIn         (liveIn),
    .rdData         (rdData)
  );

  // R1: other addresses or no strobe give an all-zero bus
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe || regAddr != ADDR_W'(REG_ADDR)) |-> (rdData == '0));

  // R4: transparent mode hides link and auto-negotiation
  p_transparent_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    transparentMode |-> (rdData[B_LINK] == 1'b0 && rdData[B_ANDONE] == 1'b0));
endmodule

// File: tb/sim_linkStatusReg.sv
module sim_linkStatusReg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = 5'd0;
  logic        rdStrobe = 1'b0;
  logic        transparentMode = 1'b0;
  logic        tpPeclMode = 1'b0;
  logic        tpNlpBurst = 1'b0;
  logic [15:0] liveIn = 16'h0;
  logic [15:0] rdData;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } itemT;

  itemT q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  linkStatusReg u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdStrobe(rdStrobe),
    .transparentMode(transparentMode), .tpPeclMode(tpPeclMode),
    .tpNlpBurst(tpNlpBurst), .liveIn(liveIn), .rdData(rdData)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic doRead(input logic [4:0] addr, input logic [15:0] exp, input string tag);
    itemT it;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    regAddr  = addr;
    rdStrobe = 1'b1;
    tick(1);
    rdStrobe = 1'b0;
    regAddr  = 5'd0;
  endtask

  // monitor: compare each read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rdStrobe) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty: rdData=%h expected none", rdData);
        end else begin
          itemT it;
          it = q.pop_front();
          if (rdData !== it.exp) begin
            errors++;
            $display("FAIL %s: rdData=%h expected %h", it.tag, rdData, it.exp);
          end
        end
      end
    end
  end

  initial begin
    // R10: link, both PLL locks live during reset
    liveIn = 16'h2801;
    tick(3);
    rstN = 1'b1;
    tick(3);
    doRead(5'd27, 16'h2801, "R10 reset state");
    doRead(5'd26, 16'h0000, "R1 wrong address");
    // R2: one-flop delay then pass-through
    liveIn = 16'h3C4B;
    doRead(5'd27, 16'h2801, "R2 old value in change cycle");
    doRead(5'd27, 16'h3C4B, "R2 live bits");
    // R3: one-cycle link drop
    liveIn = 16'h3C4A; tick(1);
    liveIn = 16'h3C4B; tick(2);
    doRead(5'd27, 16'h3C4A, "R3 drop held low");
    doRead(5'd27, 16'h3C4B, "R3 released after read");
    // R4
    transparentMode = 1'b1;
    doRead(5'd27, 16'h3C48, "R4 transparent mask");
    transparentMode = 1'b0;
    doRead(5'd27, 16'h3C4B, "R4 mask removed");
    // R5
    liveIn = 16'h3C5B; tick(1);
    liveIn = 16'h3C4B; tick(2);
    doRead(5'd27, 16'h3C5B, "R5 copper packet latched");
    doRead(5'd27, 16'h3C4B, "R5 copper packet cleared");
    liveIn = 16'h3C53; tick(1);
    liveIn = 16'h3C43; tick(2);
    doRead(5'd27, 16'h3C43, "R5 packet masked without speed");
    liveIn = 16'h3C4B; tick(2);
    doRead(5'd27, 16'h3C4B, "R5 restored speed no packet");
    // R6
    liveIn = 16'h3D4B; tick(1);
    liveIn = 16'h3C4B; tick(2);
    doRead(5'd27, 16'h3D4B, "R6 fiber packet latched");
    doRead(5'd27, 16'h3C4B, "R6 fiber packet cleared");
    liveIn = 16'h3D0B; tick(1);
    liveIn = 16'h3C0B; tick(2);
    doRead(5'd27, 16'h3C0B, "R6 packet masked without speed");
    liveIn = 16'h3C4B; tick(2);
    // R7
    liveIn = 16'hBC4B; tick(1);
    liveIn = 16'h3C4B; tick(2);
    doRead(5'd27, 16'hBC4B, "R7 no-seed latched");
    doRead(5'd27, 16'h3C4B, "R7 no-seed cleared");
    // R8
    tpNlpBurst = 1'b1; tick(1);
    doRead(5'd27, 16'h3C4B, "R8 nlp ignored without PECL");
    tpPeclMode = 1'b1;
    doRead(5'd27, 16'h3C6B, "R8 nlp sets flp bit under PECL");
    tpNlpBurst = 1'b0; tpPeclMode = 1'b0; tick(1);
    // R9: event reaches latch on the clearing edge
    liveIn = 16'h3C5B; tick(1);
    liveIn = 16'h3C4B;
    doRead(5'd27, 16'h3C4B, "R9 read before event");
    doRead(5'd27, 16'h3C5B, "R9 coincident event kept");
    doRead(5'd27, 16'h3C4B, "R9 cleared afterwards");
    tick(2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule